// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds six 8-bit configuration registers and presents them in parallel to the rest of the chip. SCL and SDA are sampled with the system clock through two-flop synchronizers. START and STOP conditions and SCL edges are found on the sampled values. The slave pulls SDA low to acknowledge and to send zero bits, and never drives it high.

A write addressed to 0xD2 (8-bit form, R/W bit included) begins with two header bytes, a command code and a byte count. The slave acknowledges both and discards them. Each data byte that follows fills the next register, starting at register 0. A read addressed to 0xD3 returns a count byte of 6, then registers 0 to 5, for as long as the host keeps acknowledging. A host NACK ends the read. Every START returns the register pointer and the header counter to zero.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the 9th clock) the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the bytes that follow are neither acknowledged nor stored until the next START.
- R2: In a write, the two bytes after the address are acknowledged and change no register.
- R3: Data bytes after the header are stored in registers 0, 1, 2, ... in arrival order. Each one is acknowledged. Register k appears on cfg_o[8k+7:8k].
- R4: Data bytes that arrive after register 5 has been written are acknowledged and dropped. The stored registers do not change.
- R5: A data byte is stored only once all 8 bits have been sampled. A STOP or START inside a byte leaves the registers unchanged.
- R6: After reset, register 0 reads 0x00 and registers 1 to 5 read 0xFF.
- R7: A read returns 0x06 first, then registers 0 to 5 in order, MSB first. Any byte requested after register 5 reads 0xFF.
- R8: A host NACK after a read byte ends the read. The slave releases SDA, and a later read starts again from the count byte.
- R9: Every START resets the register pointer and the header counter, so the next write again starts at register 0 after two header bytes.
- R10: The SDA output only pulls low. It is released at STOP and does not change while the sampled SCL stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| cfg_o | output | 48 | Register contents, register k at bits 8k+7:8k |

## Verification
Two events can fall in the same cycle: a bus condition (START or STOP) and the byte engine partway through a byte, holding a bit count and shift contents that must not reach the registers. The bench provokes this by breaking off a data byte after four bits, once with a STOP and once with a repeated START followed by a fresh write. It judges the result on cfg_o: the broken byte must never appear, and the fresh byte must land in register 0 after a new two-byte header.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_WR, PH_WR_ACK, PH_RD, PH_RD_ACK
  } ph_e;
endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  // bus idles high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      q_o    <= '1;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cfgi2c_linemon.sv
module cfgi2c_linemon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s_i;
      sda_d <= sda_s_i;
    end
  end
  assign scl_rise_o = scl_s_i & ~scl_d;
  assign scl_fall_o = ~scl_s_i & scl_d;
  assign start_o    = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_d & ~sda_d & sda_s_i;
endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      widx_i,
  input  logic [7:0]            wdata_i,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [7:0] RST_V = (k == 0) ? 8'h00 : 8'hFF;
    logic [7:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 r_q <= RST_V;
      else if (we_i && widx_i == IDX_W'(k))        r_q <= wdata_i;
    end
    assign cfg_o[8*k +: 8] = r_q;
  end
endmodule

// File: rtl/cfgi2c_ctrl.sv
module cfgi2c_ctrl
  import cfgi2c_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 6,
  parameter int unsigned HDR_BYTES = 2,
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter int unsigned IDX_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sda_s_i,
  input  logic                  scl_rise_i,
  input  logic                  scl_fall_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic [8*NUM_REGS-1:0] cfg_i,
  output logic                  we_o,
  output logic [IDX_W-1:0]      widx_o,
  output logic [7:0]            wdata_o,
  output logic                  pull_o
);
  localparam int unsigned RSEL_W = $clog2(NUM_REGS + 2);
  localparam int unsigned HC_W   = $clog2(HDR_BYTES + 1);
  localparam logic [7:0]  CNT_BYTE = 8'(NUM_REGS);

  ph_e               ph_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [HC_W-1:0]   hdr_q;
  logic [RSEL_W-1:0] rsel_q;
  logic              rd_q, ack_q;
  logic [7:0]        nxt_byte;
  logic [7:0]        rx_byte;

  always_comb begin
    nxt_byte = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++)
      if (rsel_q == RSEL_W'(k + 1)) nxt_byte = cfg_i[8*k +: 8];
  end
  assign rx_byte = {sh_q[6:0], sda_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0; idx_q <= '0; hdr_q <= '0;
      rsel_q <= '0; rd_q <= 1'b0; ack_q <= 1'b0; pull_o <= 1'b0;
      we_o <= 1'b0; widx_o <= '0; wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        ph_q <= PH_ADDR; cnt_q <= '0; idx_q <= '0; hdr_q <= '0; pull_o <= 1'b0;
      end else if (stop_i) begin
        ph_q <= PH_IDLE; pull_o <= 1'b0;
      end else begin
        unique case (ph_q)
          PH_ADDR, PH_WR: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              sh_q  <= rx_byte;
              cnt_q <= cnt_q + 4'd1;
              // commit only on the 8th sampled bit
              if (ph_q == PH_WR && cnt_q == 4'd7) begin
                if (hdr_q < HC_W'(HDR_BYTES)) begin
                  hdr_q <= hdr_q + 1'b1;
                end else if (idx_q < IDX_W'(NUM_REGS)) begin
                  we_o    <= 1'b1;
                  widx_o  <= idx_q;
                  wdata_o <= rx_byte;
                  idx_q   <= idx_q + 1'b1;
                end
              end
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (ph_q == PH_WR) begin
                pull_o <= 1'b1;
                ph_q   <= PH_WR_ACK;
              end else if (sh_q[7:1] == DEV_ADDR) begin
                pull_o <= 1'b1;
                rd_q   <= sh_q[0];
                ph_q   <= PH_ADDR_ACK;
              end else begin
                ph_q <= PH_IDLE;
              end
            end
          end
          PH_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              sh_q   <= CNT_BYTE;
              pull_o <= ~CNT_BYTE[7];
              rsel_q <= RSEL_W'(1);
              ph_q   <= PH_RD;
            end else begin
              pull_o <= 1'b0;
              ph_q   <= PH_WR;
            end
          end
          PH_WR_ACK: if (scl_fall_i) begin
            pull_o <= 1'b0;
            cnt_q  <= '0;
            ph_q   <= PH_WR;
          end
          PH_RD: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              pull_o <= 1'b0;
              ph_q   <= PH_RD_ACK;
            end else begin
              sh_q   <= {sh_q[6:0], 1'b0};
              pull_o <= ~sh_q[6];
              cnt_q  <= cnt_q + 4'd1;
            end
          end
          PH_RD_ACK: begin
            if (scl_rise_i) ack_q <= ~sda_s_i;
            else if (scl_fall_i) begin
              if (ack_q) begin
                sh_q   <= nxt_byte;
                pull_o <= ~nxt_byte[7];
                cnt_q  <= '0;
                if (rsel_q != RSEL_W'(NUM_REGS + 1)) rsel_q <= rsel_q + 1'b1;
                ph_q   <= PH_RD;
              end else begin
                ph_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int unsigned NUM_REGS  = 6,
  parameter int unsigned HDR_BYTES = 2,
  parameter logic [6:0]  DEV_ADDR  = 7'h69
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS + 1);

  logic [1:0]       sync_q;
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfgi2c_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  cfgi2c_linemon u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  cfgi2c_ctrl #(
    .NUM_REGS(NUM_REGS), .HDR_BYTES(HDR_BYTES), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .cfg_i(cfg_o),
    .we_o(wr_en), .widx_o(wr_idx), .wdata_o(wr_data), .pull_o(sda_pull_o)
  );

  cfgi2c_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .widx_i(wr_idx),
    .wdata_i(wr_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/cfgi2c_chk.sv
module cfgi2c_chk #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s_i,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  we_i,
  input logic [IDX_W-1:0]      widx_i,
  input logic                  pull_i,
  input logic [8*NUM_REGS-1:0] cfg_i
);
  // R5
  cfg_only_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_i));
  // R4
  widx_in_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> widx_i < IDX_W'(NUM_REGS));
  // R9
  start_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !we_i);
  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_i);
  // R10
  pull_quiet_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(pull_i));
endmodule

bind i2c_cfg_slave cfgi2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_i(start_det),
  .stop_i(stop_det), .we_i(wr_en), .widx_i(wr_idx), .pull_i(sda_pull_o),
  .cfg_i(cfg_o)
);

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;
  localparam int Q = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_scl = 1'b1, h_sda = 1'b1;
  logic pull;
  logic [47:0] cfg;
  wire sda_line = h_sda & ~pull;

  always #4 clk = ~clk;

  i2c_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(h_scl), .sda_i(sda_line),
    .sda_pull_o(pull), .cfg_o(cfg)
  );

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_v[$];
  string       exp_t[$];
  logic [63:0] act_v[$];
  bit done = 0;

  task automatic push_exp(logic [63:0] v, string t);
    exp_v.push_back(v); exp_t.push_back(t);
  endtask
  task automatic observe(logic [63:0] v);
    act_v.push_back(v);
  endtask

  // monitor: compares observations against expectations in order
  initial forever begin
    @(negedge clk);
    while (act_v.size() > 0 && exp_v.size() > 0) begin
      logic [63:0] a, e; string t;
      a = act_v.pop_front(); e = exp_v.pop_front(); t = exp_t.pop_front();
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i_start();
    h_sda = 1'b1; wq(); h_scl = 1'b1; wq(); h_sda = 1'b0; wq(); h_scl = 1'b0; wq();
  endtask
  task automatic i_stop();
    h_sda = 1'b0; wq(); h_scl = 1'b1; wq(); h_sda = 1'b1; wq();
  endtask
  task automatic send_bit(logic b);
    h_sda = b; wq(); h_scl = 1'b1; wq(); wq(); h_scl = 1'b0; wq();
  endtask
  task automatic recv_bit(output logic b);
    h_sda = 1'b1; wq(); h_scl = 1'b1; wq(); b = sda_line; wq(); h_scl = 1'b0; wq();
  endtask
  task automatic send_byte(logic [7:0] v, logic exp_ack, string t);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    push_exp({63'd0, exp_ack}, t); observe({63'd0, ~a});
  endtask
  task automatic recv_byte(logic [7:0] ev, logic ack_it, string t);
    logic [7:0] v; logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~ack_it);
    push_exp({56'd0, ev}, t); observe({56'd0, v});
  endtask
  task automatic chk_cfg(logic [47:0] e, string t);
    push_exp({16'd0, e}, t); observe({16'd0, cfg});
  endtask
  task automatic chk_pull(string t);
    push_exp(64'd0, t); observe({63'd0, pull});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R6 reset defaults
    chk_cfg(48'hFFFF_FFFF_FF00, "R6");
    chk_pull("R10 idle");

    // R1 R2 R3 short write
    i_start();
    send_byte(8'hD2, 1'b1, "R1 write addr");
    send_byte(8'h5A, 1'b1, "R2 cmd ack");
    send_byte(8'h03, 1'b1, "R2 count ack");
    chk_cfg(48'hFFFF_FFFF_FF00, "R2 header no effect");
    send_byte(8'h11, 1'b1, "R3 data ack");
    send_byte(8'h22, 1'b1, "R3 data ack");
    send_byte(8'h33, 1'b1, "R3 data ack");
    i_stop();
    chk_cfg(48'hFFFF_FF33_2211, "R3 ascending store");
    chk_pull("R10 stop release");

    // R4 full write plus overflow
    i_start();
    send_byte(8'hD2, 1'b1, "R1 write addr");
    send_byte(8'h00, 1'b1, "R2 cmd ack");
    send_byte(8'h00, 1'b1, "R2 count ack");
    for (int k = 0; k < 6; k++) send_byte(8'hA0 + 8'(k), 1'b1, "R3 data ack");
    chk_cfg(48'hA5A4_A3A2_A1A0, "R3 full bank");
    send_byte(8'h77, 1'b1, "R4 overflow ack");
    send_byte(8'h88, 1'b1, "R4 overflow ack");
    i_stop();
    chk_cfg(48'hA5A4_A3A2_A1A0, "R4 overflow dropped");

    // R7 full read, one extra byte, then NACK
    i_start();
    send_byte(8'hD3, 1'b1, "R1 read addr");
    recv_byte(8'h06, 1'b1, "R7 count");
    for (int k = 0; k < 6; k++) recv_byte(8'hA0 + 8'(k), 1'b1, "R7 reg");
    recv_byte(8'hFF, 1'b0, "R7 past end");
    i_stop();
    chk_pull("R8 released after nack");

    // R1 foreign address ignored
    i_start();
    send_byte(8'hA0, 1'b0, "R1 foreign addr nack");
    send_byte(8'h00, 1'b0, "R1 ignored byte");
    send_byte(8'h5C, 1'b0, "R1 ignored byte");
    i_stop();
    chk_cfg(48'hA5A4_A3A2_A1A0, "R1 foreign no store");

    // R5 byte cut by STOP
    i_start();
    send_byte(8'hD2, 1'b1, "R1 write addr");
    send_byte(8'h01, 1'b1, "R2 cmd ack");
    send_byte(8'h02, 1'b1, "R2 count ack");
    send_byte(8'h3C, 1'b1, "R3 data ack");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i_stop();
    chk_cfg(48'hA5A4_A3A2_A13C, "R5 partial byte dropped on stop");

    // R5 R9 byte cut by repeated START, then fresh write at reg 0
    i_start();
    send_byte(8'hD2, 1'b1, "R1 write addr");
    send_byte(8'h01, 1'b1, "R2 cmd ack");
    send_byte(8'h02, 1'b1, "R2 count ack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i_start();
    chk_cfg(48'hA5A4_A3A2_A13C, "R5 partial byte dropped on start");
    send_byte(8'hD2, 1'b1, "R1 write addr");
    send_byte(8'hEE, 1'b1, "R2 cmd ack");
    send_byte(8'hEE, 1'b1, "R2 count ack");
    send_byte(8'h5E, 1'b1, "R9 data ack");
    i_stop();
    chk_cfg(48'hA5A4_A3A2_A15E, "R9 restart at reg0");

    // R8 early NACK, then read restarts at count
    i_start();
    send_byte(8'hD3, 1'b1, "R1 read addr");
    recv_byte(8'h06, 1'b0, "R8 count then nack");
    i_stop();
    chk_pull("R8 released");
    i_start();
    send_byte(8'hD3, 1'b1, "R1 read addr");
    recv_byte(8'h06, 1'b1, "R8 count again");
    recv_byte(8'h5E, 1'b0, "R8 reg0 after restart");
    i_stop();

    repeat (10) @(negedge clk);
    if (exp_v.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_v.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule